// File: doc/BRIEF.md
# Dual-Table Huffman Block Decoder

This block expands one variable-length-coded data block back into its 64 sixteen-bit symbols. Every block can be coded either exactly or with quantized symbols. A one-bit mode flag in the block header tells which coding was used. The decoder keeps two programmable lookup banks, one for exact symbols and one for quantized symbols, and the mode flag picks one of them for the whole block. Software, or a neighbouring controller, fills both banks through a write port before any decoding starts.

The coded stream arrives as one wide vector. It must stay unchanged from the start pulse until the block finishes. The header holds the mode flag and three byte pointers, and these split the stream into four segments of sixteen symbols each. A single decode lane works through the segments one after another. It takes one symbol per clock and jumps to the next pointer when a segment is complete. The decoded symbols are packed in pairs into 32-bit words, and each word leaves with its index. A done flag marks a complete block. An error flag marks a stream in which no table entry matches.

Top module: `hdec_dual_table`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o` and `word_valid_o` are all low, and every table entry is invalid.
- R2: Stream bit 0 is the mode flag: 0 means exact, 1 means quantized. Pointer s (s = 0..2) sits in stream bits [1+7s +: 7], least significant bit at the lower index, and gives a byte offset. Segment 0 starts at stream bit 22.
- R3: A `start_i` pulse while idle makes `busy_o` high in the next cycle and clears `done_o` and `err_o`. A `start_i` pulse while busy is ignored.
- R4: A codeword is read most significant bit first from the stream, and its value sits right-aligned in `tbl_code_i`. When several valid entries match, the entry with the longest length wins, whatever its index.
- R5: An entry with the escape flag set takes the 16 stream bits that follow its codeword as the symbol, with the first bit as the most significant bit.
- R6: Mode 0 decodes the whole block with bank 0. Mode 1 decodes it with bank 1.
- R7: In mode 1, every output symbol has its low 4 bits forced to zero. This applies to table symbols and to escaped symbols.
- R8: Each segment holds 16 symbols. After the last symbol of segment s, decoding continues at stream bit 8 × pointer s.
- R9: Symbols 2j and 2j+1 form word j, with the earlier symbol in bits [15:0]. Each word is shown for one cycle with `word_valid_o` and `word_idx_o` = j.
- R10: `done_o` rises in the same cycle as word 31 and stays high until the next start. `done_o` and `err_o` are never high together.
- R11: When no valid entry of the selected bank matches, `err_o` is set, `busy_o` drops in the same cycle, and no further words appear.
- R12: A table write changes only the entry at `tbl_idx_i` in the bank chosen by `tbl_bank_i` (0 or 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_bank_i | input | 1 | Bank to write: 0 exact, 1 quantized |
| tbl_idx_i | input | 3 | Entry index |
| tbl_valid_i | input | 1 | Entry valid |
| tbl_esc_i | input | 1 | Entry is the escape codeword |
| tbl_len_i | input | 4 | Codeword length in bits (1..8) |
| tbl_code_i | input | 8 | Codeword value, right-aligned |
| tbl_sym_i | input | 16 | Symbol produced by the entry |
| start_i | input | 1 | Start decoding the presented block |
| blk_i | input | 1024 | Coded block, stream bit i at index i |
| busy_o | output | 1 | Decoding in progress |
| word_valid_o | output | 1 | Output word valid this cycle |
| word_idx_o | output | 5 | Index of the output word |
| word_o | output | 32 | Two decoded symbols |
| done_o | output | 1 | Block complete, sticky until next start |
| err_o | output | 1 | No codeword matched, sticky until next start |

## Verification
Sixteen is even, so a segment always ends on a completed word. On that edge the decoder both emits a word and jumps to the next pointer. The final symbol also raises the done flag in the same cycle as the last word. The bench spaces the segments with variable gaps of all-ones padding, which would decode as garbage or as an error if the jump came one cycle late or early. It then compares every word, including the ones at segment edges and the final word, against symbols computed arithmetically.

// File: rtl/hdec_pkg.sv
// Shared constants and types for the dual-table decoder.
// Assumes 16-bit symbols packed two per output word.
package hdec_pkg;
    localparam int SYM_W  = 16;
    localparam int WORD_W = 2 * SYM_W;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } dec_state_t;
endpackage

// File: rtl/hdec_table_bank.sv
// One programmable decode bank: ENTRIES (codeword, length, symbol, escape)
// records with a write port, plus a parallel longest-prefix matcher.
// Assumes code bits above the entry length are written as zero.
module hdec_table_bank #(
    parameter int ENTRIES = 8,
    parameter int MAX_LEN = 8,
    parameter int SYM_W   = 16,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic               valid_i,
    input  logic               esc_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic [MAX_LEN-1:0] code_i,
    input  logic [SYM_W-1:0]   sym_i,
    input  logic [MAX_LEN-1:0] peek_i,
    output logic               hit_o,
    output logic [LEN_W-1:0]   hit_len_o,
    output logic               hit_esc_o,
    output logic [SYM_W-1:0]   hit_sym_o
);
    logic               valid_q [ENTRIES];
    logic               esc_q   [ENTRIES];
    logic [LEN_W-1:0]   len_q   [ENTRIES];
    logic [MAX_LEN-1:0] code_q  [ENTRIES];
    logic [SYM_W-1:0]   sym_q   [ENTRIES];

    // Valid bits: cleared by reset, set or cleared by a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) valid_q[e] <= 1'b0;
        end else if (we_i) begin
            valid_q[idx_i] <= valid_i;
        end
    end

    // Entry payload: written alongside the valid bit, no reset needed.
    always_ff @(posedge clk) begin
        if (we_i) begin
            esc_q[idx_i]  <= esc_i;
            len_q[idx_i]  <= len_i;
            code_q[idx_i] <= code_i;
            sym_q[idx_i]  <= sym_i;
        end
    end

    // Longest-prefix search over all entries in one cycle.
    always_comb begin
        hit_o     = 1'b0;
        hit_len_o = '0;
        hit_esc_o = 1'b0;
        hit_sym_o = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (valid_q[e] && len_q[e] != '0 && int'(len_q[e]) <= MAX_LEN &&
                (peek_i >> (MAX_LEN - int'(len_q[e]))) == code_q[e] &&
                len_q[e] > hit_len_o) begin
                hit_o     = 1'b1;
                hit_len_o = len_q[e];
                hit_esc_o = esc_q[e];
                hit_sym_o = sym_q[e];
            end
        end
    end
endmodule

// File: rtl/hdec_window.sv
// Bit window: returns PEEK_W stream bits starting at position pos_i, the
// first stream bit in the most significant place. Bits past the end read 0.
module hdec_window #(
    parameter int STREAM_W = 1024,
    parameter int PEEK_W   = 24,
    parameter int POS_W    = 11,
    localparam int AW      = $clog2(STREAM_W)
) (
    input  logic [STREAM_W-1:0] bits_i,
    input  logic [POS_W-1:0]    pos_i,
    output logic [PEEK_W-1:0]   peek_o
);
    // One multiplexer per window bit, reversed so the stream reads MSB first.
    always_comb begin
        for (int k = 0; k < PEEK_W; k++) begin
            logic [POS_W:0] ix;
            ix = {1'b0, pos_i} + (POS_W + 1)'(k);
            peek_o[PEEK_W-1-k] = (int'(ix) < STREAM_W) ? bits_i[ix[AW-1:0]] : 1'b0;
        end
    end
endmodule

// File: rtl/hdec_dual_table.sv
// Dual-table block decoder. Reads the mode flag and segment pointers from
// the header, then decodes one symbol per cycle with the bank chosen by the
// mode flag. Symbols are paired into words. Assumes blk_i is held constant
// from start until done or error, and that tables are written only while idle.
module hdec_dual_table
    import hdec_pkg::*;
#(
    parameter int BLOCK_BYTES = 128,
    parameter int SEGS        = 4,
    parameter int ENTRIES     = 8,
    parameter int MAX_LEN     = 8,
    parameter int QBITS       = 4,
    localparam int STREAM_W   = BLOCK_BYTES * 8,
    localparam int PTR_W      = $clog2(BLOCK_BYTES),
    localparam int NSYM       = BLOCK_BYTES / 2,
    localparam int SEG_SYMS   = NSYM / SEGS,
    localparam int SEG_SH     = $clog2(SEG_SYMS),
    localparam int HDR_W      = 1 + (SEGS - 1) * PTR_W,
    localparam int POS_W      = $clog2(STREAM_W) + 1,
    localparam int IDX_W      = $clog2(ENTRIES),
    localparam int LEN_W      = $clog2(MAX_LEN + 1),
    localparam int CNT_W      = $clog2(NSYM),
    localparam int WIDX_W     = CNT_W - 1,
    localparam int PEEK_W     = MAX_LEN + SYM_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tbl_we_i,
    input  logic                tbl_bank_i,
    input  logic [IDX_W-1:0]    tbl_idx_i,
    input  logic                tbl_valid_i,
    input  logic                tbl_esc_i,
    input  logic [LEN_W-1:0]    tbl_len_i,
    input  logic [MAX_LEN-1:0]  tbl_code_i,
    input  logic [SYM_W-1:0]    tbl_sym_i,
    input  logic                start_i,
    input  logic [STREAM_W-1:0] blk_i,
    output logic                busy_o,
    output logic                word_valid_o,
    output logic [WIDX_W-1:0]   word_idx_o,
    output logic [WORD_W-1:0]   word_o,
    output logic                done_o,
    output logic                err_o
);
    localparam logic [SYM_W-1:0] QMASK = SYM_W'((1 << QBITS) - 1);

    dec_state_t         state_q;
    logic               lossy_q;
    logic [PTR_W-1:0]   ptr_q [SEGS-1];
    logic [POS_W-1:0]   pos_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [SYM_W-1:0]   lo_q;

    logic [PEEK_W-1:0]  win;
    logic               b_hit [2];
    logic [LEN_W-1:0]   b_len [2];
    logic               b_esc [2];
    logic [SYM_W-1:0]   b_sym [2];

    logic               sel_hit, sel_esc;
    logic [LEN_W-1:0]   sel_len;
    logic [SYM_W-1:0]   sel_sym, raw_sym, sym_out;
    logic [PEEK_W-1:0]  shifted;
    logic [POS_W-1:0]   adv, seg_start;
    logic               seg_last;

    hdec_window #(.STREAM_W(STREAM_W), .PEEK_W(PEEK_W), .POS_W(POS_W)) u_win (
        .bits_i (blk_i),
        .pos_i  (pos_q),
        .peek_o (win)
    );

    // Two identical banks: bank 0 exact symbols, bank 1 quantized symbols.
    for (genvar b = 0; b < 2; b++) begin : g_bank
        hdec_table_bank #(.ENTRIES(ENTRIES), .MAX_LEN(MAX_LEN), .SYM_W(SYM_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .we_i      (tbl_we_i && (tbl_bank_i == 1'(b))),
            .idx_i     (tbl_idx_i),
            .valid_i   (tbl_valid_i),
            .esc_i     (tbl_esc_i),
            .len_i     (tbl_len_i),
            .code_i    (tbl_code_i),
            .sym_i     (tbl_sym_i),
            .peek_i    (win[PEEK_W-1 -: MAX_LEN]),
            .hit_o     (b_hit[b]),
            .hit_len_o (b_len[b]),
            .hit_esc_o (b_esc[b]),
            .hit_sym_o (b_sym[b])
        );
    end

    // Per-block arbitration between banks and symbol formation.
    always_comb begin
        sel_hit  = b_hit[lossy_q];
        sel_len  = b_len[lossy_q];
        sel_esc  = b_esc[lossy_q];
        sel_sym  = b_sym[lossy_q];
        shifted  = win << sel_len;
        raw_sym  = shifted[PEEK_W-1 -: SYM_W];
        sym_out  = sel_esc ? raw_sym : sel_sym;
        if (lossy_q) sym_out = sym_out & ~QMASK;
        adv      = POS_W'(sel_len) + (sel_esc ? POS_W'(SYM_W) : '0);
    end

    // Segment bookkeeping: is this the last symbol of a segment, and where next.
    always_comb begin
        seg_last  = &cnt_q[SEG_SH-1:0];
        seg_start = '0;
        for (int s = 0; s < SEGS - 1; s++) begin
            if (int'(cnt_q >> SEG_SH) == s) seg_start = POS_W'({ptr_q[s], 3'b000});
        end
    end

    // Control, position, pairing and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            lossy_q      <= 1'b0;
            pos_q        <= '0;
            cnt_q        <= '0;
            lo_q         <= '0;
            word_valid_o <= 1'b0;
            word_idx_o   <= '0;
            word_o       <= '0;
            done_o       <= 1'b0;
            err_o        <= 1'b0;
            for (int s = 0; s < SEGS - 1; s++) ptr_q[s] <= '0;
        end else begin
            word_valid_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        lossy_q <= blk_i[0];
                        for (int s = 0; s < SEGS - 1; s++)
                            ptr_q[s] <= blk_i[1 + s * PTR_W +: PTR_W];
                        pos_q   <= POS_W'(HDR_W);
                        cnt_q   <= '0;
                        done_o  <= 1'b0;
                        err_o   <= 1'b0;
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (!sel_hit) begin
                        err_o   <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                        if (!cnt_q[0]) begin
                            lo_q <= sym_out;
                        end else begin
                            word_o       <= {sym_out, lo_q};
                            word_valid_o <= 1'b1;
                            word_idx_o   <= cnt_q[CNT_W-1:1];
                        end
                        pos_q <= seg_last ? seg_start : pos_q + adv;
                        if (int'(cnt_q) == NSYM - 1) begin
                            done_o  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q == ST_RUN);
endmodule

// File: rtl/hdec_checker.sv
// Protocol checker for hdec_dual_table, attached by bind below.
module hdec_checker #(
    parameter int WIDX_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              word_valid_o,
    input logic [WIDX_W-1:0] word_idx_o,
    input logic              done_o,
    input logic              err_o
);
    // R10: completion and failure exclude each other
    assert_done_err_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    // R10: done arrives together with the last word
    assert_done_with_last_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (word_valid_o && (&word_idx_o)));

    // R9: words come only out of a running decode
    assert_word_from_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> $past(busy_o));

    // R3: start in idle launches a clean run
    assert_start_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && !done_o && !err_o));

    // R11: an error ends the run without a word
    assert_err_stops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> (!busy_o && !word_valid_o));
endmodule

bind hdec_dual_table hdec_checker #(.WIDX_W(WIDX_W)) u_hdec_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .word_valid_o (word_valid_o),
    .word_idx_o   (word_idx_o),
    .done_o       (done_o),
    .err_o        (err_o)
);

// File: tb/tb_hdec_dual_table.sv
module tb_hdec_dual_table;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0, tbl_bank = 1'b0, tbl_valid = 1'b0, tbl_esc = 1'b0;
    logic [2:0]  tbl_idx = '0;
    logic [3:0]  tbl_len = '0;
    logic [7:0]  tbl_code = '0;
    logic [15:0] tbl_sym = '0;
    logic        start = 1'b0;
    logic [1023:0] stream = '1;
    logic        busy, wv, done, err;
    logic [4:0]  widx;
    logic [31:0] word;

    int applied = 0;
    int fails = 0;
    logic [31:0] got [32];
    int got_cnt = 0;
    logic [15:0] exp_sym [64];
    logic        exp_esc [64];
    logic [15:0] lsym [5];
    logic [15:0] qsym [5];

    always #10 clk = ~clk;

    hdec_dual_table dut (
        .clk(clk), .rst_n(rst_n),
        .tbl_we_i(tbl_we), .tbl_bank_i(tbl_bank), .tbl_idx_i(tbl_idx),
        .tbl_valid_i(tbl_valid), .tbl_esc_i(tbl_esc), .tbl_len_i(tbl_len),
        .tbl_code_i(tbl_code), .tbl_sym_i(tbl_sym),
        .start_i(start), .blk_i(stream),
        .busy_o(busy), .word_valid_o(wv), .word_idx_o(widx), .word_o(word),
        .done_o(done), .err_o(err)
    );

    // Collect output words by index.
    always @(negedge clk) begin
        if (wv) begin
            got[widx] = word;
            got_cnt++;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        applied++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit bank, input int idx, input bit v, input bit e,
                      input int len, input int code, input logic [15:0] sym);
        @(negedge clk);
        tbl_we = 1'b1; tbl_bank = bank; tbl_idx = 3'(idx); tbl_valid = v;
        tbl_esc = e; tbl_len = 4'(len); tbl_code = 8'(code); tbl_sym = sym;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // Choice c<5: codeword of c+1 bits (c ones then a zero); c==5: escape 111110.
    task automatic put(inout int p, input int len, input int val);
        for (int k = 0; k < len; k++) stream[p + k] = val[len - 1 - k];
        p += len;
    endtask

    task automatic build(input bit mode, input int a, input int b, input int gap, input int seed);
        int p;
        stream = '1;
        stream[0] = mode;
        p = 22;
        for (int s = 0; s < 4; s++) begin
            if (s > 0) begin
                p = ((p + 7) / 8) * 8 + 8 * ((gap * s) % 3);
                stream[1 + 7 * (s - 1) +: 7] = 7'(p / 8);
            end
            for (int j = 0; j < 16; j++) begin
                int i, c;
                logic [15:0] raw, v;
                i = s * 16 + j;
                c = (i * a + b + (i >> 3)) % 6;
                raw = 16'h9000 + 16'(i * 16'h0123) ^ 16'(seed);
                if (c < 5) begin
                    put(p, c + 1, (1 << (c + 1)) - 2);
                    v = mode ? qsym[c] : lsym[c];
                end else begin
                    put(p, 6, 62);
                    put(p, 16, int'(raw));
                    v = raw;
                end
                exp_sym[i] = mode ? (v & 16'hFFF0) : v;
                exp_esc[i] = (c == 5);
            end
        end
    endtask

    task automatic run_block(input bit mode, input bit restart_mid, input string name);
        int t;
        got_cnt = 0;
        for (int w = 0; w < 32; w++) got[w] = '0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy === 1'b1 && done === 1'b0, {name, " R3 busy after start"}, {31'd0, busy}, 32'd1);
        if (restart_mid) begin
            repeat (10) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        t = 0;
        while (!done && !err && t < 400) begin @(negedge clk); t++; end
        @(negedge clk);
        check(done === 1'b1 && err === 1'b0 && busy === 1'b0 && got_cnt == 32,
              {name, " R10 done with 32 words R2"}, 32'(got_cnt), 32'd32);
        for (int w = 0; w < 32; w++) begin
            logic [31:0] e;
            string tag;
            e = {exp_sym[2 * w + 1], exp_sym[2 * w]};
            tag = (exp_esc[2 * w] || exp_esc[2 * w + 1]) ? "R5" :
                  (w % 8 == 7) ? "R8" : (mode ? "R7" : "R9");
            check(got[w] === e, $sformatf("%s %s R6 R4 word %0d", name, tag, w), got[w], e);
        end
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
        $finish;
    end

    initial begin
        int p, t, c0;
        lsym = '{16'h1234, 16'h4321, 16'hBEEF, 16'h0F0F, 16'hC0DE};
        qsym = '{16'h5A5B, 16'hA0A7, 16'h3C3D, 16'hFFFF, 16'h1111};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 0 && done === 0 && err === 0 && wv === 0, "R1 reset state",
              {28'd0, busy, done, err, wv}, 32'd0);

        // R12 loading; R4: a one-bit "1" entry at index 0 of bank 0 must lose to longer matches.
        wr(0, 0, 1, 0, 1, 1, 16'h7777);
        for (int c = 0; c < 5; c++) wr(0, c + 1, 1, 0, c + 1, (1 << (c + 1)) - 2, lsym[c]);
        wr(0, 6, 1, 1, 6, 62, 16'h0000);
        wr(0, 7, 0, 0, 0, 0, 16'h0000);
        for (int c = 0; c < 5; c++) wr(1, c, 1, 0, c + 1, (1 << (c + 1)) - 2, 16'hEEEE);
        wr(1, 5, 1, 1, 6, 62, 16'h0000);
        wr(1, 6, 0, 0, 0, 0, 16'h0000);
        wr(1, 7, 0, 0, 0, 0, 16'h0000);
        for (int c = 0; c < 5; c++) wr(1, c, 1, 0, c + 1, (1 << (c + 1)) - 2, qsym[c]);

        build(0, 1, 0, 1, 16'h0011); run_block(0, 0, "exact-a");
        build(0, 5, 2, 2, 16'h0A0A); run_block(0, 1, "exact-restart");
        build(1, 1, 3, 1, 16'h0B0C); run_block(1, 0, "quant-a");
        build(1, 7, 1, 2, 16'h1357); run_block(1, 0, "quant-b");

        // R12: rewrite a bank-1 entry; bank 0 must be unaffected, bank 1 must follow.
        qsym[0] = 16'h2229;
        wr(1, 0, 1, 0, 1, 0, qsym[0]);
        build(0, 3, 4, 0, 16'h00FF); run_block(0, 0, "R12-exact");
        build(1, 3, 4, 0, 16'h00FF); run_block(1, 0, "R12-quant");

        // R11: three symbols, then 111111 which bank 1 cannot match.
        stream = '1;
        stream[0] = 1'b1;
        p = 22;
        put(p, 1, 0); put(p, 2, 2); put(p, 3, 6);
        got_cnt = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        t = 0;
        while (!done && !err && t < 200) begin @(negedge clk); t++; end
        c0 = got_cnt;
        check(err === 1'b1 && done === 1'b0 && busy === 1'b0, "R11 error flags",
              {29'd0, err, done, busy}, 32'h4);
        check(c0 == 1 && got[0] === {qsym[1] & 16'hFFF0, qsym[0] & 16'hFFF0},
              "R11 words before error", got[0], {qsym[1] & 16'hFFF0, qsym[0] & 16'hFFF0});
        repeat (5) @(negedge clk);
        check(got_cnt == 1 && err === 1'b1, "R11 no words after error", 32'(got_cnt), 32'd1);

        // R3: a fresh start clears the sticky error.
        build(0, 2, 1, 1, 16'h4242); run_block(0, 0, "after-error");

        $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
        $finish;
    end
endmodule